// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches a port of input pins and raises a single interrupt line when any pin shows an event that software has enabled. Each pin is first brought into the local clock domain. It can then pass through a per-pin stability filter. After that it is judged either on its level or on a transition, in the direction chosen per pin.

Transition events are held in a sticky per-pin flag until software acknowledges them. Level events are not stored: they follow the pin. Software sees two views of the events. One is unfiltered by the enable mask; the other is gated by it. The interrupt output is asserted while any gated bit is set.

All configuration goes through a small register port: a byte address, a write strobe, write data and combinational read data. Registers sit on word-aligned byte offsets and hold one bit per pin. A usual reconfiguration is to clear the enable mask, change polarity and then mode, and enable again. Changing a pin's configuration never leaves a stale or false flag behind.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers decode at these byte offsets: mode 0x00, polarity 0x04, acknowledge 0x08, enable 0x0C, gated status 0x10, ungated status 0x14, filter enable 0x18. Mode, polarity, enable and filter enable read back what was written. The acknowledge offset reads as zero.
- R2: After reset every register and every stored event is zero and `irq_o` is low.
- R3: A pin with mode bit 0 is level-sensitive. Its ungated status bit equals the qualified pin level when its polarity bit is 1, and the inverted level when it is 0. The bit is not stored, and writing 1 to it at the acknowledge offset changes nothing.
- R4: A pin with mode bit 1 is transition-sensitive. A rising qualified input (polarity 1) or a falling one (polarity 0) sets its status bit. The bit stays set afterwards; a transition in the other direction does not set it.
- R5: Writing the acknowledge offset clears the stored event of each pin whose data bit is 1. Bits written as 0 leave their events untouched.
- R6: When a new transition event and an acknowledge for the same pin fall in the same clock cycle, the bit stays set. A pin change is sampled through two synchroniser flops and one history flop, so its event is stored on the third clock edge after the change.
- R7: Gated status equals ungated status ANDed with the enable register. `irq_o` is high exactly when gated status is nonzero.
- R8: With its filter enable bit set, a pin's new level is passed on only after the synchronised input has held it for DB_CYCLES consecutive samples (default 4). A 3-cycle pulse is then ignored and a 4-cycle pulse is seen. With the bit clear, a 3-cycle pulse does set an event.
- R9: A write to the mode or polarity offset clears the stored event of every pin whose bit it changes. Pins whose bit it leaves unchanged keep their events. A configuration change never creates an event by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The detector is driven with the following patterns, each of which separates one behaviour from another:
- Held levels on level-sensitive pins show that the status follows the pin and survives an acknowledge.
- Rise-then-fall and fall-then-rise pulses on transition pins show that only the chosen direction is stored.
- An acknowledge placed in exactly the cycle a fresh transition arrives, on a bit that was already set, separates "event wins" from "clear wins". It also pins down the three-edge latency.
- Pulses of three and four cycles on a filtered pin, and three cycles on an unfiltered one, mark the filter's exact threshold.
- Polarity and mode rewrites with a mix of changed and unchanged bits show that only the changed pins lose their stored events.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam logic [7:0] OFS_MODE = 8'h00;
   localparam logic [7:0] OFS_POL  = 8'h04;
   localparam logic [7:0] OFS_ACK  = 8'h08;
   localparam logic [7:0] OFS_EN   = 8'h0C;
   localparam logic [7:0] OFS_STAT = 8'h10;
   localparam logic [7:0] OFS_RAW  = 8'h14;
   localparam logic [7:0] OFS_FILT = 8'h18;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_MODE, SEL_POL, SEL_ACK, SEL_EN, SEL_STAT, SEL_RAW, SEL_FILT
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [7:0] a);
      case (a)
         OFS_MODE: return SEL_MODE;
         OFS_POL:  return SEL_POL;
         OFS_ACK:  return SEL_ACK;
         OFS_EN:   return SEL_EN;
         OFS_STAT: return SEL_STAT;
         OFS_RAW:  return SEL_RAW;
         OFS_FILT: return SEL_FILT;
         default:  return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
   parameter int W      = 8,
   parameter int CYCLES = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (CYCLES <= 1) begin : g_pass
      assign q = d;
   end else begin : g_count
      localparam int CNT_W = $clog2(CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

      for (genvar i = 0; i < W; i++) begin : g_pin
         logic [CNT_W-1:0] cnt_q;
         logic             stable_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q    <= '0;
               stable_q <= 1'b0;
            end else if (d[i] == stable_q) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               stable_q <= d[i];
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign q[i] = stable_q;
      end
   end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] edge_mode,
   input  logic [W-1:0] rise_hi,
   input  logic [W-1:0] ack_clr,
   input  logic [W-1:0] cfg_clr,
   output logic [W-1:0] ev_set,
   output logic [W-1:0] raw
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hold_q;
   logic [W-1:0] rise, fall, hold_d;

   assign rise   = lvl & ~prev_q;
   assign fall   = ~lvl & prev_q;
   assign ev_set = edge_mode & ((rise_hi & rise) | (~rise_hi & fall));

   // a configuration change discards the old event and the one seen under the old setting
   assign hold_d = ((hold_q & ~(ack_clr | cfg_clr)) | (ev_set & ~cfg_clr)) & edge_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         hold_q <= '0;
      end else begin
         prev_q <= lvl;
         hold_q <= hold_d;
      end
   end

   assign raw = (edge_mode & hold_q) | (~edge_mode & ~(lvl ^ rise_hi));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int DB_CYCLES   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [NUM_PINS-1:0] bus_wdata,
   output logic [NUM_PINS-1:0] bus_rdata,
   output logic                irq_o
);
   localparam int W = NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("NUM_PINS must be 1..32");
   end
   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must be 5..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DB_CYCLES < 1) begin : g_bad_db
      $error("DB_CYCLES must be at least 1");
   end

   reg_sel_e     sel;
   logic [W-1:0] mode_q, pol_q, en_q, filt_q;
   logic [W-1:0] synced, filtered, qual;
   logic [W-1:0] ack_clr, cfg_clr, ev_set, raw_stat;
   logic         wr_mode, wr_pol;

   assign sel     = decode_addr(8'(bus_addr));
   assign wr_mode = bus_wr && (sel == SEL_MODE);
   assign wr_pol  = bus_wr && (sel == SEL_POL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pol_q  <= '0;
         en_q   <= '0;
         filt_q <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_MODE: mode_q <= bus_wdata;
            SEL_POL:  pol_q  <= bus_wdata;
            SEL_EN:   en_q   <= bus_wdata;
            SEL_FILT: filt_q <= bus_wdata;
            default:  ;
         endcase
      end
   end

   assign ack_clr = (bus_wr && sel == SEL_ACK) ? bus_wdata : '0;
   assign cfg_clr = (wr_mode ? (bus_wdata ^ mode_q) : '0)
                  | (wr_pol  ? (bus_wdata ^ pol_q)  : '0);

   gpio_irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_i),
      .q     (synced)
   );

   gpio_irq_filter #(.W(W), .CYCLES(DB_CYCLES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (synced),
      .q     (filtered)
   );

   assign qual = (filt_q & filtered) | (~filt_q & synced);

   gpio_irq_detect #(.W(W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl       (qual),
      .edge_mode (mode_q),
      .rise_hi   (pol_q),
      .ack_clr   (ack_clr),
      .cfg_clr   (cfg_clr),
      .ev_set    (ev_set),
      .raw       (raw_stat)
   );

   always_comb begin
      case (sel)
         SEL_MODE: bus_rdata = mode_q;
         SEL_POL:  bus_rdata = pol_q;
         SEL_EN:   bus_rdata = en_q;
         SEL_FILT: bus_rdata = filt_q;
         SEL_STAT: bus_rdata = raw_stat & en_q;
         SEL_RAW:  bus_rdata = raw_stat;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_o = |(raw_stat & en_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [NUM_PINS-1:0] bus_wdata,
   input logic [NUM_PINS-1:0] bus_rdata,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] mode_q,
   input logic [NUM_PINS-1:0] en_q,
   input logic [NUM_PINS-1:0] raw_stat,
   input logic [NUM_PINS-1:0] ev_set
);
   reg_sel_e sel;
   assign sel = decode_addr(8'(bus_addr));

   assert_reset_idle_R2: assert property (@(posedge clk)
      !rst_n |=> !irq_o);

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ((raw_stat & $past(raw_stat & mode_q)) == $past(raw_stat & mode_q)));

   assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_ACK) |=> ((raw_stat & mode_q & $past(bus_wdata & ~ev_set)) == '0));

   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_set != '0) && !(bus_wr && (sel == SEL_MODE || sel == SEL_POL)))
      |=> ((raw_stat & $past(ev_set)) == $past(ev_set)));

   assert_stat_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_STAT) |-> (((bus_rdata & ~en_q) == '0) && (irq_o == (bus_rdata != '0))));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .mode_q    (mode_q),
   .en_q      (en_q),
   .raw_stat  (raw_stat),
   .ev_set    (ev_set)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
   import gpio_irq_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] pin_i;
   logic [4:0] bus_addr;
   logic       bus_wr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       irq_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   gpio_irq_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a falling edge; sampled by the next rising edge
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr  = a[4:0];
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a[4:0];
      #2;
      d = bus_rdata;
   endtask

   task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset;
      chk_reg("R2 mode", OFS_MODE, 8'h00);
      chk_reg("R2 pol", OFS_POL, 8'h00);
      chk_reg("R2 en", OFS_EN, 8'h00);
      chk_reg("R2 filt", OFS_FILT, 8'h00);
      chk_reg("R2 stat", OFS_STAT, 8'h00);
      chk("R2 irq", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_regs;
      @(negedge clk);
      wr(OFS_MODE, 8'hA5);
      wr(OFS_POL, 8'h3C);
      wr(OFS_EN, 8'h00);
      wr(OFS_FILT, 8'h81);
      chk_reg("R1 mode", OFS_MODE, 8'hA5);
      chk_reg("R1 pol", OFS_POL, 8'h3C);
      chk_reg("R1 filt", OFS_FILT, 8'h81);
      chk_reg("R1 ack reads 0", OFS_ACK, 8'h00);
      @(negedge clk);
      wr(OFS_EN, 8'h5A);
      chk_reg("R1 en", OFS_EN, 8'h5A);
      @(negedge clk);
      wr(OFS_EN, 8'h00);
      wr(OFS_FILT, 8'h00);
      wr(OFS_MODE, 8'h00);
      wr(OFS_POL, 8'h00);
   endtask

   task automatic t_level;
      wr(OFS_POL, 8'h01);
      wr(OFS_EN, 8'h01);
      wait_cyc(4);
      chk_reg("R3 idle raw", OFS_RAW, 8'hFE);
      chk("R3 idle irq", {7'd0, irq_o}, 8'h00);
      @(negedge clk);
      pin_i[0] = 1'b1;
      wait_cyc(4);
      chk_reg("R3 high raw", OFS_RAW, 8'hFF);
      chk_reg("R3 high stat", OFS_STAT, 8'h01);
      chk("R3 irq", {7'd0, irq_o}, 8'h01);
      @(negedge clk);
      wr(OFS_ACK, 8'h01);
      chk_reg("R3 ack ignored", OFS_RAW, 8'hFF);
      @(negedge clk);
      pin_i[0] = 1'b0;
      wait_cyc(4);
      chk_reg("R3 follows low", OFS_RAW, 8'hFE);
      chk("R3 irq low", {7'd0, irq_o}, 8'h00);
      @(negedge clk);
      wr(OFS_EN, 8'h00);
   endtask

   task automatic t_edge;
      wr(OFS_POL, 8'h02);
      wr(OFS_MODE, 8'hFF);
      wait_cyc(2);
      chk_reg("R4 clear start", OFS_RAW, 8'h00);
      @(negedge clk);
      pin_i[1] = 1'b1;
      wait_cyc(4);
      chk_reg("R4 rise set", OFS_RAW, 8'h02);
      @(negedge clk);
      pin_i[1] = 1'b0;
      wait_cyc(4);
      chk_reg("R4 sticky", OFS_RAW, 8'h02);
      @(negedge clk);
      pin_i[2] = 1'b1;
      wait_cyc(4);
      chk_reg("R4 wrong dir", OFS_RAW, 8'h02);
      @(negedge clk);
      pin_i[2] = 1'b0;
      wait_cyc(4);
      chk_reg("R4 fall set", OFS_RAW, 8'h06);
      chk("R7 irq masked off", {7'd0, irq_o}, 8'h00);
   endtask

   task automatic t_ack;
      @(negedge clk);
      wr(OFS_ACK, 8'h04);
      chk_reg("R5 ack one", OFS_RAW, 8'h02);
      @(negedge clk);
      wr(OFS_ACK, 8'h00);
      chk_reg("R5 zero no effect", OFS_RAW, 8'h02);
      @(negedge clk);
      wr(OFS_ACK, 8'h02);
      chk_reg("R5 ack rest", OFS_RAW, 8'h00);
   endtask

   task automatic t_mask;
      @(negedge clk);
      pin_i[1] = 1'b1;
      wait_cyc(4);
      wr(OFS_EN, 8'h04);
      chk_reg("R7 other enable", OFS_STAT, 8'h00);
      chk("R7 irq other", {7'd0, irq_o}, 8'h00);
      @(negedge clk);
      wr(OFS_EN, 8'h02);
      chk_reg("R7 gated", OFS_STAT, 8'h02);
      chk("R7 irq on", {7'd0, irq_o}, 8'h01);
      @(negedge clk);
      wr(OFS_ACK, 8'h02);
      chk("R7 irq off", {7'd0, irq_o}, 8'h00);
      @(negedge clk);
      pin_i[1] = 1'b0;
      wr(OFS_EN, 8'h00);
      wait_cyc(4);
   endtask

   task automatic t_race;
      pin_i[1] = 1'b1;
      wait_cyc(4);
      pin_i[1] = 1'b0;
      wait_cyc(4);
      chk_reg("R6 preset", OFS_RAW, 8'h02);
      @(negedge clk);
      pin_i[1] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(OFS_ACK, 8'h02);
      chk_reg("R6 event wins", OFS_RAW, 8'h02);
      @(negedge clk);
      wr(OFS_ACK, 8'h02);
      chk_reg("R6 later ack", OFS_RAW, 8'h00);
   endtask

   task automatic t_reconfig;
      @(negedge clk);
      pin_i[1] = 1'b0;
      wait_cyc(3);
      pin_i[1] = 1'b1;
      pin_i[3] = 1'b1;
      wait_cyc(4);
      pin_i[3] = 1'b0;
      wait_cyc(4);
      chk_reg("R9 preset", OFS_RAW, 8'h0A);
      @(negedge clk);
      wr(OFS_POL, 8'h0A);
      chk_reg("R9 changed bit cleared", OFS_RAW, 8'h02);
      wait_cyc(3);
      chk_reg("R9 no spurious", OFS_RAW, 8'h02);
      @(negedge clk);
      wr(OFS_ACK, 8'hFF);
      pin_i[1] = 1'b0;
      wait_cyc(4);
      wr(OFS_ACK, 8'hFF);
   endtask

   task automatic pulse(input int pin, input int len);
      @(negedge clk);
      pin_i[pin] = 1'b1;
      wait_cyc(len);
      pin_i[pin] = 1'b0;
      wait_cyc(10);
   endtask

   task automatic t_filter;
      wr(OFS_POL, 8'hFF);
      wr(OFS_FILT, 8'h10);
      wait_cyc(4);
      pulse(4, 3);
      chk_reg("R8 short blocked", OFS_RAW, 8'h00);
      pulse(4, 4);
      chk_reg("R8 threshold passes", OFS_RAW, 8'h10);
      @(negedge clk);
      wr(OFS_ACK, 8'h10);
      pulse(5, 3);
      chk_reg("R8 unfiltered short seen", OFS_RAW, 8'h20);
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      pin_i     = '0;
      bus_addr  = '0;
      bus_wr    = 1'b0;
      bus_wdata = '0;
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_level;
      t_edge;
      t_ack;
      t_mask;
      t_race;
      t_reconfig;
      t_filter;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule